// File: doc/BRIEF.md
# SCSI Selection Response Filter

This block observes the SCSI bus while another device tries to select or reselect the local target. It resynchronises the data lines, the two byte-lane parity bits and the BSY, SEL and I/O control lines. It waits until the sampled bus has held still for a programmable number of cycles. It then judges the attempt once and reports one of three results: a one-cycle response pulse (selection or reselection) together with the initiator's ID, a one-cycle ignored pulse, or nothing when the attempt addresses another device.

Three configuration bits steer the judgement. The first rejects legacy attempts in which only the target's own ID line is driven, so that a single flipped bit cannot pass for such an attempt. The second declares that every device on the bus is 16 bits wide: the upper byte of ID lines and its parity bit then take part in the decision. The third enables parity checking and a sticky error flag. The local ID and the configuration bits are treated as quasi-static and are sampled directly.

Top module: `scsi_sel_filter`

## Requirements
- R1: After a synchronous reset, sel_pulse, resel_pulse, ignore_pulse and par_err are 0 and init_id is 0.
- R2: An attempt exists while SEL is high and BSY is low. It is judged once, and the result is registered exactly SETTLE_CYC+2 rising edges after the first edge that samples its final bus value. A response is sel_pulse when I/O is low and resel_pulse when I/O is high. At most one of the three pulses is high in a cycle, and each lasts one cycle.
- R3: If the local ID line and exactly one other ID line are high, the block responds and init_id holds the index of the other line.
- R4: If the local ID line is the only high ID line, the block responds with init_id equal to the local ID when cfg_no_single is 0, and gives ignore_pulse instead when cfg_no_single is 1.
- R5: More than two high ID lines give ignore_pulse and no response, whether or not the local line is among them.
- R6: An attempt with at most two high ID lines and the local line low gives no pulse at all.
- R7: With cfg_wide at 0, data lines 15..8 and parity bit 1 have no effect, and a local ID of 8 or above is never addressed.
- R8: Parity is odd: bus_db[7:0] together with bus_dp[0] must hold an odd number of ones, and likewise bus_db[15:8] with bus_dp[1]. When cfg_par_en is 1, a failing low byte, or a failing high byte while cfg_wide is 1, gives ignore_pulse and sets par_err. This check takes priority over the ID-line rules.
- R9: With cfg_wide at 1, a failing upper byte parity gives ignore_pulse even when cfg_par_en is 0 (an 8-bit device that does not drive that bit), and par_err is then left unchanged.
- R10: par_err stays set until a cycle with perr_clr high. If a new parity failure is registered in the same cycle as a clear, the flag stays set.
- R11: A change of the bus inside an attempt, before it is judged, restarts the settle count. The attempt is still judged only once, on its final value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_db | input | 16 | Bus data/ID lines, high means asserted |
| bus_dp | input | 2 | Odd parity bit per byte lane (bit 0 for lines 7..0) |
| bus_bsy | input | 1 | BSY line, high means asserted |
| bus_sel | input | 1 | SEL line, high means asserted |
| bus_io | input | 1 | I/O line, high marks a reselection |
| my_id | input | 4 | Local target ID |
| cfg_no_single | input | 1 | Reject attempts where only the local line is driven |
| cfg_wide | input | 1 | All devices 16-bit: use the upper byte and its parity |
| cfg_par_en | input | 1 | Enable parity checking and the error flag |
| perr_clr | input | 1 | Write strobe that clears par_err |
| sel_pulse | output | 1 | One-cycle selection response |
| resel_pulse | output | 1 | One-cycle reselection response |
| ignore_pulse | output | 1 | One-cycle rejected-attempt indication |
| par_err | output | 1 | Sticky parity error flag |
| init_id | output | 4 | Initiator ID, valid with a response pulse |

## Verification
The assertions check on every cycle that the three result pulses are mutually exclusive and one cycle wide. They also check that par_err rises only together with a rejection while parity checking is enabled, and that a clear strobe leaves the flag low unless a new failure arrives. Further assertions check that a response never reports the local ID while single-initiator rejection is active, and never reports an ID of 8 or above in narrow mode. The bench scenarios are needed for the parts that depend on the data pattern: the initiator index chosen from two lines, the over-populated and not-addressed cases, the odd-parity rule on each lane, the 8-bit device rejected without a parity flag, the exact settle latency, and the restart after a mid-attempt change.

// File: rtl/scsi_sel_filter_pkg.sv
package scsi_sel_filter_pkg;

  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_ACCEPT = 2'd1,
    VERD_IGNORE = 2'd2
  } verdict_t;

endpackage

// File: rtl/selfilt_sync.sv
module selfilt_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/selfilt_settle.sv
module selfilt_settle #(
  parameter int W          = 8,
  parameter int SETTLE_CYC = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word,
  input  logic         active,
  output logic         fire
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [W-1:0]     hold;
  logic [CNT_W-1:0] cnt;
  logic             done;
  logic             same;

  assign same = (word == hold);
  assign fire = active && same && (cnt == LAST) && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      hold <= word;
      if (!active || !same) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      if (!active) done <= 1'b0;
      else if (fire) done <= 1'b1;
    end
  end
endmodule

// File: rtl/selfilt_judge.sv
module selfilt_judge
  import scsi_sel_filter_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int LANES = 1 << ID_W,
  localparam int BYTES = LANES / 8,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] db,
  input  logic [BYTES-1:0] dp,
  input  logic [ID_W-1:0]  my_id,
  input  logic             cfg_no_single,
  input  logic             cfg_wide,
  input  logic             cfg_par_en,
  output verdict_t         verdict,
  output logic             perr,
  output logic [ID_W-1:0]  who
);
  logic [BYTES-1:0] lane_on, lane_ok;
  logic [LANES-1:0] ids;
  logic [CW-1:0]    nbits;
  logic [ID_W-1:0]  other;
  logic             upper_bad, mine;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    assign lane_ok[g] = ^{db[g*8 +: 8], dp[g]};
    if (g == 0) begin : g_base
      assign lane_on[g] = 1'b1;
    end else begin : g_upper
      assign lane_on[g] = cfg_wide;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign ids[i] = db[i] & lane_on[i/8];
  end

  assign perr      = cfg_par_en && |(lane_on & ~lane_ok);
  assign upper_bad = |((lane_on & ~lane_ok) >> 1);
  assign mine      = ids[my_id];

  always_comb begin
    nbits = '0;
    other = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ids[i]) begin
        nbits = nbits + 1'b1;
        if (ID_W'(i) != my_id) other = ID_W'(i);
      end
    end
  end

  always_comb begin
    verdict = VERD_NONE;
    who     = my_id;
    if (perr || upper_bad)         verdict = VERD_IGNORE;
    else if (nbits > CW'(2))       verdict = VERD_IGNORE;
    else if (!mine)                verdict = VERD_NONE;
    else if (nbits == CW'(1))      verdict = cfg_no_single ? VERD_IGNORE : VERD_ACCEPT;
    else begin
      verdict = VERD_ACCEPT;
      who     = other;
    end
  end
endmodule

// File: rtl/scsi_sel_filter.sv
module scsi_sel_filter
  import scsi_sel_filter_pkg::*;
#(
  parameter int ID_W       = 4,
  parameter int SETTLE_CYC = 3,
  parameter int SYNC_DEPTH = 2,
  localparam int LANES = 1 << ID_W,
  localparam int BYTES = LANES / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] bus_db,
  input  logic [BYTES-1:0] bus_dp,
  input  logic             bus_bsy,
  input  logic             bus_sel,
  input  logic             bus_io,
  input  logic [ID_W-1:0]  my_id,
  input  logic             cfg_no_single,
  input  logic             cfg_wide,
  input  logic             cfg_par_en,
  input  logic             perr_clr,
  output logic             sel_pulse,
  output logic             resel_pulse,
  output logic             ignore_pulse,
  output logic             par_err,
  output logic [ID_W-1:0]  init_id
);
  localparam int WW = LANES + BYTES + 3;

  logic [WW-1:0]    raw_w, s_w;
  logic [LANES-1:0] s_db;
  logic [BYTES-1:0] s_dp;
  logic             s_bsy, s_sel, s_io, s_active, fire, perr;
  logic [ID_W-1:0]  who;
  verdict_t         verdict;

  assign raw_w = {bus_io, bus_sel, bus_bsy, bus_dp, bus_db};

  selfilt_sync #(.W(WW), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .d(raw_w), .q(s_w)
  );

  assign s_db     = s_w[LANES-1:0];
  assign s_dp     = s_w[LANES +: BYTES];
  assign s_bsy    = s_w[LANES+BYTES];
  assign s_sel    = s_w[LANES+BYTES+1];
  assign s_io     = s_w[LANES+BYTES+2];
  assign s_active = s_sel && !s_bsy;

  selfilt_settle #(.W(WW), .SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .word(s_w), .active(s_active), .fire(fire)
  );

  selfilt_judge #(.ID_W(ID_W)) u_judge (
    .db(s_db), .dp(s_dp), .my_id(my_id),
    .cfg_no_single(cfg_no_single), .cfg_wide(cfg_wide), .cfg_par_en(cfg_par_en),
    .verdict(verdict), .perr(perr), .who(who)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_pulse    <= 1'b0;
      resel_pulse  <= 1'b0;
      ignore_pulse <= 1'b0;
      par_err      <= 1'b0;
      init_id      <= '0;
    end else begin
      sel_pulse    <= fire && (verdict == VERD_ACCEPT) && !s_io;
      resel_pulse  <= fire && (verdict == VERD_ACCEPT) && s_io;
      ignore_pulse <= fire && (verdict == VERD_IGNORE);
      if (fire && (verdict == VERD_ACCEPT)) init_id <= who;
      if (fire && perr) par_err <= 1'b1;
      else if (perr_clr) par_err <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_sel_filter_chk.sv
module scsi_sel_filter_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [ID_W-1:0] my_id,
  input logic            cfg_no_single,
  input logic            cfg_wide,
  input logic            cfg_par_en,
  input logic            perr_clr,
  input logic            sel_pulse,
  input logic            resel_pulse,
  input logic            ignore_pulse,
  input logic            par_err,
  input logic [ID_W-1:0] init_id
);
  logic any_resp, any_pulse;
  assign any_resp  = sel_pulse || resel_pulse;
  assign any_pulse = any_resp || ignore_pulse;

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_pulse, resel_pulse, ignore_pulse}));

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    any_pulse |=> !any_pulse);

  // R8
  perr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> (ignore_pulse && $past(cfg_par_en)));

  // R10
  perr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    perr_clr |=> (!par_err || ignore_pulse));

  // R4
  single_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (any_resp && cfg_no_single && $past(cfg_no_single) && $stable(my_id))
      |-> (init_id != my_id));

  // R7
  narrow_id_chk: assert property (@(posedge clk) disable iff (rst)
    (any_resp && !cfg_wide && $past(!cfg_wide))
      |-> ({1'b0, init_id} < (ID_W+1)'(8)));
endmodule

bind scsi_sel_filter scsi_sel_filter_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .my_id(my_id), .cfg_no_single(cfg_no_single),
  .cfg_wide(cfg_wide), .cfg_par_en(cfg_par_en), .perr_clr(perr_clr),
  .sel_pulse(sel_pulse), .resel_pulse(resel_pulse), .ignore_pulse(ignore_pulse),
  .par_err(par_err), .init_id(init_id)
);

// File: tb/sim_scsi_sel_filter.sv
`timescale 1ns/1ps
module sim_scsi_sel_filter;
  localparam int SETTLE = 3;

  logic        clk = 0, rst = 1;
  logic [15:0] bus_db = '0;
  logic [1:0]  bus_dp = '0;
  logic        bus_bsy = 0, bus_sel = 0, bus_io = 0;
  logic [3:0]  my_id = 4'd5;
  logic        cfg_no_single = 0, cfg_wide = 0, cfg_par_en = 1, perr_clr = 0;
  logic        sel_pulse, resel_pulse, ignore_pulse, par_err;
  logic [3:0]  init_id;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0;

  always #2 clk = ~clk;

  scsi_sel_filter #(.ID_W(4), .SETTLE_CYC(SETTLE), .SYNC_DEPTH(2)) u0 (
    .clk(clk), .rst(rst), .bus_db(bus_db), .bus_dp(bus_dp), .bus_bsy(bus_bsy),
    .bus_sel(bus_sel), .bus_io(bus_io), .my_id(my_id), .cfg_no_single(cfg_no_single),
    .cfg_wide(cfg_wide), .cfg_par_en(cfg_par_en), .perr_clr(perr_clr),
    .sel_pulse(sel_pulse), .resel_pulse(resel_pulse), .ignore_pulse(ignore_pulse),
    .par_err(par_err), .init_id(init_id)
  );

  // verdict: 0 none, 1 respond, 2 ignore
  function automatic void decide(input logic [15:0] d, input logic [1:0] p,
                                 input bit wide, input bit pen, input bit nos,
                                 input int id, output int verdict,
                                 output bit pe, output int oid);
    bit lo_ok = (^{d[7:0], p[0]}) == 1'b1;
    bit hi_ok = (^{d[15:8], p[1]}) == 1'b1;
    int top = wide ? 16 : 8;
    int n = 0;
    bit local_on = 0;
    oid = id;
    pe = pen && (!lo_ok || (wide && !hi_ok));
    if (pe || (wide && !hi_ok)) begin
      verdict = 2;
      return;
    end
    for (int i = 0; i < top; i++) begin
      if (d[i]) begin
        n++;
        if (i == id) local_on = 1;
        else oid = i;
      end
    end
    if (n > 2) verdict = 2;
    else if (!local_on) verdict = 0;
    else if (n == 1) verdict = nos ? 2 : 1;
    else verdict = 1;
    if (verdict != 1) oid = id;
  endfunction

  // behavioural reference
  logic [20:0] prev_raw = '0;
  int  stable_run = 0;
  bit  used = 0;
  bit  e_sel = 0, e_resel = 0, e_ign = 0, e_perr = 0;
  int  e_id = 0;

  always @(posedge clk) begin
    logic [20:0] raw;
    int v, oid;
    bit pe;
    raw = {bus_io, bus_sel, bus_bsy, bus_dp, bus_db};
    started = 1;
    e_sel = 0; e_resel = 0; e_ign = 0;
    if (rst) begin
      e_perr = 0; e_id = 0; used = 0; stable_run = 0;
    end else begin
      if (raw == prev_raw) begin
        if (stable_run < 1000) stable_run++;
      end else stable_run = 0;
      if (!(bus_sel && !bus_bsy)) used = 0;
      if (bus_sel && !bus_bsy && !used && stable_run == SETTLE + 2) begin
        used = 1;
        decide(bus_db, bus_dp, cfg_wide, cfg_par_en, cfg_no_single, my_id, v, pe, oid);
        if (v == 1) begin
          if (bus_io) e_resel = 1; else e_sel = 1;
          e_id = oid;
        end else if (v == 2) e_ign = 1;
        if (pe) e_perr = 1;
        else if (perr_clr) e_perr = 0;
      end else if (perr_clr) e_perr = 0;
    end
    prev_raw = raw;
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (sel_pulse !== e_sel || resel_pulse !== e_resel || ignore_pulse !== e_ign ||
          par_err !== e_perr || ((e_sel || e_resel) && init_id !== 4'(e_id))) begin
        errors++;
        $display("FAIL %s t=%0t: actual sel=%b resel=%b ign=%b perr=%b id=%0d expected sel=%b resel=%b ign=%b perr=%b id=%0d",
                 cur_req, $time, sel_pulse, resel_pulse, ignore_pulse, par_err, init_id,
                 e_sel, e_resel, e_ign, e_perr, e_id);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic idle(int n);
    bus_sel = 0; bus_bsy = 0; bus_io = 0; bus_db = '0; bus_dp = 2'b11;
    repeat (n) @(negedge clk);
  endtask

  task automatic attempt(string tag, logic [15:0] d, bit bad_lo, bit bad_hi, bit io);
    cur_req = tag;
    @(negedge clk);
    bus_db = d;
    bus_dp[0] = ~(^d[7:0]) ^ bad_lo;
    bus_dp[1] = ~(^d[15:8]) ^ bad_hi;
    bus_io = io; bus_bsy = 0; bus_sel = 1;
    repeat (14) @(negedge clk);
    idle(8);
  endtask

  task automatic expect_now(string tag, bit s, bit r, bit ig, bit pe);
    checks++;
    if (sel_pulse !== s || resel_pulse !== r || ignore_pulse !== ig || par_err !== pe) begin
      errors++;
      $display("FAIL %s: actual %b%b%b%b expected %b%b%b%b", tag,
               sel_pulse, resel_pulse, ignore_pulse, par_err, s, r, ig, pe);
    end
  endtask

  initial begin
    idle(1);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_now("R1", 0, 0, 0, 0);
    checks++;
    if (init_id !== 4'd0) begin
      errors++;
      $display("FAIL R1: actual id=%0d expected 0", init_id);
    end
    idle(4);

    // R3 two lines: selection and reselection
    attempt("R3", 16'h0024, 0, 0, 0);
    attempt("R3", 16'h00A0, 0, 0, 1);
    attempt("R3", 16'h0021, 0, 0, 0);
    // R4 single initiator
    attempt("R4", 16'h0020, 0, 0, 0);
    cfg_no_single = 1;
    attempt("R4", 16'h0020, 0, 0, 0);
    attempt("R4", 16'h0030, 0, 0, 1);
    // R5 too many lines
    attempt("R5", 16'h002A, 0, 0, 0);
    attempt("R5", 16'h000E, 0, 0, 0);
    // R6 not addressed
    attempt("R6", 16'h0006, 0, 0, 0);
    attempt("R6", 16'h0000, 0, 0, 0);
    // R7 narrow mode ignores upper byte
    attempt("R7", 16'h1020, 0, 1, 0);
    cfg_no_single = 0;
    attempt("R7", 16'hF020, 0, 1, 0);
    my_id = 4'd12;
    attempt("R7", 16'h1008, 0, 0, 0);
    my_id = 4'd5;
    // R8 low byte parity
    attempt("R8", 16'h0024, 1, 0, 0);
    // R10 flag sticky, then cleared
    attempt("R10", 16'h0024, 0, 0, 0);
    @(negedge clk); perr_clr = 1;
    @(negedge clk); perr_clr = 0;
    idle(3);
    // R8 parity off: bad low parity has no effect
    cfg_par_en = 0;
    attempt("R8", 16'h0024, 1, 0, 0);
    cfg_par_en = 1;
    // R9 wide system
    cfg_wide = 1; my_id = 4'd12;
    attempt("R9", 16'h1200, 0, 0, 0);
    attempt("R9", 16'h1004, 0, 0, 1);
    attempt("R9", 16'h1200, 0, 1, 0);
    cfg_par_en = 0;
    attempt("R9", 16'h1200, 0, 1, 0);
    @(negedge clk); perr_clr = 1;
    @(negedge clk); perr_clr = 0;
    my_id = 4'd3;
    attempt("R9", 16'h000A, 0, 1, 0);
    cfg_par_en = 1; cfg_wide = 0; my_id = 4'd5;
    // R10 clear strobe held across a new failure
    cur_req = "R10";
    perr_clr = 1;
    attempt("R10", 16'h0024, 1, 0, 0);
    perr_clr = 0;
    idle(2);
    // R11 change before settling, then BSY blocks (R2)
    cur_req = "R11";
    @(negedge clk);
    bus_db = 16'h0024; bus_dp = {1'b1, ~(^8'h24)}; bus_sel = 1;
    @(negedge clk);
    bus_db = 16'h0030; bus_dp = {1'b1, ~(^8'h30)};
    repeat (14) @(negedge clk);
    idle(8);
    cur_req = "R2";
    bus_bsy = 1;
    @(negedge clk);
    bus_db = 16'h0024; bus_dp = {1'b1, ~(^8'h24)}; bus_sel = 1; bus_bsy = 1;
    repeat (14) @(negedge clk);
    idle(8);
    attempt("R2", 16'h0060, 0, 0, 1);

    summary();
    $finish;
  end
endmodule